// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Controller

This block resolves read-after-write dependences for the execute stage of a five-stage, single-issue, in-order integer pipeline with 32 architectural registers. For each of the two ALU operands, it compares the source register number of the instruction in execute against the destination numbers of the two older instructions still in flight. One is the instruction in the memory stage and the other is the instruction in write-back. From that comparison it produces a 2-bit select code, and it steers the matching operand multiplexer to one of three values: the register-file read value, the memory-stage ALU result, or the final write-back result.

The block is purely combinational. It settles within the execute cycle, and the surrounding pipeline registers supply all of its inputs. Register zero is hardwired to zero, so a write that names it never produces a bypass. When both older instructions write the source register, the younger one, in the memory stage, supplies the value. This way a chain of instructions that each update the same register always sees its immediate predecessor's result.

Top module: `fwd_bypass_unit`

## Requirements
- R1: When the memory stage writes (`mem_we`=1) a nonzero destination equal to `ex_src_a`, `sel_a` is 2'b10 and `opnd_a` equals `mem_alu_res`.
- R2: When the memory stage writes a nonzero destination equal to `ex_src_b`, `sel_b` is 2'b10 and `opnd_b` equals `mem_alu_res`.
- R3: When the write-back stage writes (`wb_we`=1) a nonzero destination equal to a source, and the memory stage does not match that source, the select is 2'b01 and the operand equals `wb_result`.
- R4: When both stages match the same source, the select is 2'b10 and the operand is `mem_alu_res`.
- R5: A destination of register 0 never forwards, even with its write enable high; the select stays 2'b00.
- R6: A stage whose write enable is low never forwards, whatever its destination number.
- R7: With no match, the select is 2'b00 and the operand equals the register-file value (`rf_a` or `rf_b`); the code 2'b11 is never produced.
- R8: Each operand is decided on its own, so A and B may take different sources in the same cycle.
- R9: In a chain of instructions that each read and write the same register, every instruction after the second receives its immediate predecessor's result through select 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register of the instruction in execute |
| ex_src_b | input | 5 | Second source register of the instruction in execute |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register of the write-back-stage instruction |
| wb_we | input | 1 | Write-back-stage instruction writes a register |
| rf_a | input | 32 | Register-file read value for operand A |
| rf_b | input | 32 | Register-file read value for operand B |
| mem_alu_res | input | 32 | ALU result held in the execute/memory pipeline register |
| wb_result | input | 32 | Final write-back value (load data or ALU result) |
| sel_a | output | 2 | Operand A select: 00 register file, 01 write-back, 10 memory stage |
| sel_b | output | 2 | Operand B select, same encoding |
| opnd_a | output | 32 | Selected ALU operand A |
| opnd_b | output | 32 | Selected ALU operand B |

## Verification
The bench covers every combination of source, memory destination and write-back destination over registers 0 to 7, with all four write-enable pairings. This reaches the corner cases:
- A design that forgot the register-zero exclusion would bypass a stale write into a read of the zero register.
- A design with the priority reversed would hand a chained instruction the value from two instructions back.
- A design that ignored the write enables would forward from stores and branches.

Directed cases add a same-cycle split, with A taken from the memory stage and B from write-back, and a three-instruction chain that updates one register in every instruction.

// File: rtl/fwd_pkg.sv
// Package: shared select encoding and sizing for the operand bypass controller.
// Assumes a two-bit select per operand; code 3 is reserved and never driven.
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,   // register-file read value
        SEL_WB  = 2'b01,   // write-back final result
        SEL_MEM = 2'b10,   // memory-stage ALU result
        SEL_RSV = 2'b11    // reserved, treated as register file
    } fwd_sel_e;

    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/fwd_match.sv
// Module: fwd_match
// Decides whether one older pipeline stage produces the register that one
// execute-stage source reads. Assumes register 0 is hardwired to zero, so a
// write that names it is never a producer.
module fwd_match #(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] src,
    input  logic [IDX_W-1:0] dst,
    input  logic             we,
    output logic             hit
);

    logic dst_live;
    logic same_reg;

    // Purpose: qualify the destination, then compare it with the source.
    always_comb begin
        dst_live = we && (dst != '0);
        same_reg = (dst == src);
        hit      = dst_live && same_reg;
    end

    // Purpose: a zero source can never be reported as produced (R5).
    always_comb begin
        p_zero_src_r5: assert (!(hit && (src == '0)))
            else $error("zero register reported as forwarded");
    end

endmodule

// File: rtl/fwd_select.sv
// Module: fwd_select
// Chooses the bypass source for one ALU operand from the two older stages.
// Assumes the memory stage holds the younger producer, so it wins ties.
module fwd_select
    import fwd_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] src,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic             mem_we,
    input  logic [IDX_W-1:0] wb_dst,
    input  logic             wb_we,
    output fwd_sel_e         sel
);

    logic mem_hit;
    logic wb_hit;

    fwd_match #(.IDX_W(IDX_W)) i_mem_match (
        .src (src),
        .dst (mem_dst),
        .we  (mem_we),
        .hit (mem_hit)
    );

    fwd_match #(.IDX_W(IDX_W)) i_wb_match (
        .src (src),
        .dst (wb_dst),
        .we  (wb_we),
        .hit (wb_hit)
    );

    // Purpose: priority pick, youngest producer first.
    always_comb begin
        if (mem_hit)     sel = SEL_MEM;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_RF;
    end

    // Purpose: guard the priority and the encoding against regressions.
    always_comb begin
        p_wb_yields_r4: assert (!(sel == SEL_WB && mem_dst == src && mem_we && src != '0))
            else $error("write-back chosen over matching memory stage");
        p_never_rsv_r7: assert (sel != SEL_RSV)
            else $error("reserved select code driven");
        p_idle_stage_r6: assert (!(sel != SEL_RF && !mem_we && !wb_we))
            else $error("forward without any writing stage");
    end

endmodule

// File: rtl/fwd_opmux.sv
// Module: fwd_opmux
// Three-way operand multiplexer steered by a bypass select code.
// Assumes the reserved code falls back to the register-file value.
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd
);

    // Purpose: route the selected source onto the ALU operand.
    always_comb begin
        unique case (sel)
            SEL_MEM: opnd = mem_val;
            SEL_WB:  opnd = wb_val;
            default: opnd = rf_val;
        endcase
    end

endmodule

// File: rtl/fwd_bypass_unit.sv
// Module: fwd_bypass_unit (top)
// Execute-stage operand bypass controller with its two operand multiplexers.
// Assumes a purely combinational path settling inside the execute cycle and
// a write-back value that is already the final (load or ALU) result.
module fwd_bypass_unit
    import fwd_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]  ex_src_a,
    input  logic [IDX_W-1:0]  ex_src_b,
    input  logic [IDX_W-1:0]  mem_dst,
    input  logic              mem_we,
    input  logic [IDX_W-1:0]  wb_dst,
    input  logic              wb_we,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] mem_alu_res,
    input  logic [DATA_W-1:0] wb_result,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    logic [IDX_W-1:0]  src_v  [NUM_OPERANDS];
    logic [DATA_W-1:0] rf_v   [NUM_OPERANDS];
    logic [DATA_W-1:0] opnd_v [NUM_OPERANDS];
    fwd_sel_e          sel_v  [NUM_OPERANDS];

    assign src_v[0] = ex_src_a;
    assign src_v[1] = ex_src_b;
    assign rf_v[0]  = rf_a;
    assign rf_v[1]  = rf_b;

    // One selector and one multiplexer per operand, decided independently (R8).
    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
        fwd_select #(.IDX_W(IDX_W)) i_select (
            .src     (src_v[g]),
            .mem_dst (mem_dst),
            .mem_we  (mem_we),
            .wb_dst  (wb_dst),
            .wb_we   (wb_we),
            .sel     (sel_v[g])
        );

        fwd_opmux #(.DATA_W(DATA_W)) i_mux (
            .sel     (sel_v[g]),
            .rf_val  (rf_v[g]),
            .mem_val (mem_alu_res),
            .wb_val  (wb_result),
            .opnd    (opnd_v[g])
        );
    end

    assign sel_a  = sel_v[0];
    assign sel_b  = sel_v[1];
    assign opnd_a = opnd_v[0];
    assign opnd_b = opnd_v[1];

    // Purpose: the operand follows the select that the selector reported.
    always_comb begin
        p_mem_path_r1: assert (!(sel_a == 2'b10) || opnd_a == mem_alu_res)
            else $error("operand A ignores memory-stage select");
        p_mem_path_r2: assert (!(sel_b == 2'b10) || opnd_b == mem_alu_res)
            else $error("operand B ignores memory-stage select");
        p_wb_path_r3: assert (!(sel_a == 2'b01) || opnd_a == wb_result)
            else $error("operand A ignores write-back select");
        p_rf_path_r7: assert (!(sel_b == 2'b00) || opnd_b == rf_b)
            else $error("operand B ignores register-file select");
    end

endmodule

// File: tb/test_fwd_bypass_unit.sv
// Bench: sweeps sources and destinations over registers 0..7 with every
// write-enable pairing, plus directed split-operand and chain cases.
module test_fwd_bypass_unit;

    localparam int IDX_W  = 5;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [IDX_W-1:0]  ex_src_a, ex_src_b, mem_dst, wb_dst;
    logic              mem_we, wb_we;
    logic [DATA_W-1:0] rf_a, rf_b, mem_alu_res, wb_result;
    logic [1:0]        sel_a, sel_b;
    logic [DATA_W-1:0] opnd_a, opnd_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fwd_bypass_unit i_fwd_bypass_unit (
        .ex_src_a, .ex_src_b, .mem_dst, .mem_we, .wb_dst, .wb_we,
        .rf_a, .rf_b, .mem_alu_res, .wb_result,
        .sel_a, .sel_b, .opnd_a, .opnd_b
    );

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_sel(input int src, input int md, input bit mwe,
                                           input int wd, input bit wwe);
        if (mwe && md != 0 && md == src)      return 2'b10;
        else if (wwe && wd != 0 && wd == src) return 2'b01;
        else                                  return 2'b00;
    endfunction

    function automatic string tag_of(input int src, input int md, input bit mwe,
                                     input int wd, input bit wwe, input bit is_b);
        bit mh = mwe && md != 0 && md == src;
        bit wh = wwe && wd != 0 && wd == src;
        if (mh && wh) return "R4";
        if (mh)       return is_b ? "R2" : "R1";
        if (wh)       return "R3";
        if (src == 0 && ((mwe && md == 0) || (wwe && wd == 0))) return "R5";
        if (md == src || wd == src) return "R6";
        return "R7";
    endfunction

    task automatic drive(input int sa, input int sb, input int md, input bit mwe,
                         input int wd, input bit wwe);
        @(negedge clk);
        ex_src_a = IDX_W'(sa);  ex_src_b = IDX_W'(sb);
        mem_dst  = IDX_W'(md);  mem_we   = mwe;
        wb_dst   = IDX_W'(wd);  wb_we    = wwe;
        rf_a = 32'hA000_0000 + 32'(sa);
        rf_b = 32'hA100_0000 + 32'(sb);
        mem_alu_res = 32'hB000_0000 + 32'(md);
        wb_result   = 32'hC000_0000 + 32'(wd);
        #1;
    endtask

    function automatic logic [DATA_W-1:0] ref_val(input logic [1:0] s,
            input logic [DATA_W-1:0] rf);
        case (s)
            2'b10:   return mem_alu_res;
            2'b01:   return wb_result;
            default: return rf;
        endcase
    endfunction

    initial begin
        // Watchdog: a hung run counts as a failed check.
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] ea, eb;
        ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
        mem_we = 1'b0; wb_we = 1'b0;
        rf_a = '0; rf_b = '0; mem_alu_res = '0; wb_result = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: nothing writes, both operands from register file (R7).
        drive(3, 4, 3, 0, 4, 0);
        check("R7", "idle sel_a", 32'(sel_a), 32'(2'b00));
        check("R7", "idle opnd_b", opnd_b, rf_b);

        // Exhaustive sweep over registers 0..7 and all enable pairings.
        for (int we = 0; we < 4; we++)
            for (int s = 0; s < 8; s++)
                for (int m = 0; m < 8; m++)
                    for (int w = 0; w < 8; w++) begin
                        int sb = (s * 3 + 1) % 8;
                        drive(s, sb, m, we[0], w, we[1]);
                        ea = ref_sel(s, m, we[0], w, we[1]);
                        eb = ref_sel(sb, m, we[0], w, we[1]);
                        check(tag_of(s, m, we[0], w, we[1], 0), "sweep sel_a", 32'(sel_a), 32'(ea));
                        check(tag_of(s, m, we[0], w, we[1], 0), "sweep opnd_a", opnd_a, ref_val(ea, rf_a));
                        check(tag_of(sb, m, we[0], w, we[1], 1), "sweep sel_b", 32'(sel_b), 32'(eb));
                        check(tag_of(sb, m, we[0], w, we[1], 1), "sweep opnd_b", opnd_b, ref_val(eb, rf_b));
                    end

        // Top register index, zero destination with enables high (R5).
        drive(0, 31, 0, 1, 31, 1);
        check("R5", "zero src sel_a", 32'(sel_a), 32'(2'b00));
        check("R3", "r31 sel_b", 32'(sel_b), 32'(2'b01));

        // Split: A from memory stage, B from write-back in one cycle (R8).
        drive(6, 9, 6, 1, 9, 1);
        check("R8", "split sel_a", 32'(sel_a), 32'(2'b10));
        check("R8", "split sel_b", 32'(sel_b), 32'(2'b01));
        check("R8", "split opnd_b", opnd_b, 32'hC000_0009);

        // Chain: three updates of register 1 each reading register 1 (R9).
        // Second instruction: only the first is older, sitting in memory stage.
        drive(1, 2, 1, 1, 0, 0);
        mem_alu_res = 32'd100; #1;
        check("R9", "chain step2 opnd_a", opnd_a, 32'd100);
        // Third instruction: second in memory, first in write-back.
        drive(1, 3, 1, 1, 1, 1);
        mem_alu_res = 32'd200; wb_result = 32'd100; #1;
        check("R9", "chain step3 sel_a", 32'(sel_a), 32'(2'b10));
        check("R9", "chain step3 opnd_a", opnd_a, 32'd200);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule